// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Port

This block is the digital side of one sampling converter on a three-wire serial bus. The bus has a convert strobe, a serial clock and a serial data input, and the block drives one serial data output. Several of these ports can be cascaded by connecting each data output to the next device's data input. The host then clocks the whole chain as one long shift register and reads every device's result, the device nearest the host first.

A rising convert strobe while the serial clock is low starts a conversion. The conversion takes a fixed number of system clocks, set by a parameter. At its end, the 16-bit parallel result input is captured and its most significant bit appears on the data output at once. Each later falling serial clock edge moves the word one place toward the output and pulls in the bit present on the data input. The upstream data therefore follows the local result. All bus inputs are synchronised into the system clock domain and edge-detected there. A falling convert strobe ends the readback.

Top module: `chain_adc_port`

## Requirements
- R1: While the convert strobe is low and the port is idle, the data output is 0, whatever the data input does. This includes the state after reset.
- R2: A rising convert strobe seen while the serial clock is low starts a conversion. The data output stays 0 for the CONV_CYCLES system clocks of the conversion. After that, it shows bit 15 of the result.
- R3: Serial clock edges that arrive during a conversion do not shift the word and do not alter the readback that follows.
- R4: A rising convert strobe seen while the serial clock is high starts nothing. The output stays 0, and later serial clock falls leave it at 0.
- R5: In readback, each falling serial clock edge advances the output by one bit. The 16 result bits appear in order from bit 15 down to bit 0.
- R6: The data input is captured on each falling serial clock edge and shifted in at the least significant end. The bit captured on fall k appears on the output after fall k+15.
- R7: The data output changes only after a falling serial clock edge. It holds its value across the high phase of the serial clock, so it is valid on both clock edges.
- R8: A falling convert strobe during conversion or readback returns the port to idle with the output at 0. A later conversion then behaves normally.
- R9: The result input is captured at the end of the conversion, not at its start.
- R10: Two cascaded ports deliver 32 bits on the downstream output: the downstream result first, then the upstream result, each from bit 15 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_i | input | 1 | Convert strobe, asynchronous to clk |
| sck_i | input | 1 | Serial clock, asynchronous to clk |
| sdi_i | input | 1 | Serial data from the upstream device |
| result_i | input | 16 | Parallel conversion result |
| sdo_o | output | 1 | Serial data toward the host |

## Verification
Random result words are read back with random data-input patterns and stream lengths of 16 to 24 bits. This separates a correct result order from a reversed order, and it shows whether upstream bits are taken at the right place and with the right delay. Directed cases cover the following:
- Serial clock pulses during a conversion, which expose a shifter that is not gated.
- A start with the serial clock high, which must do nothing.
- A result word that changes during the conversion, which tells capture at the end from capture at the start.
- An abort in the middle of a readback.
- A two-device cascade, which shows whether the serial input is really fed through from the upstream port.

// File: rtl/chain_port_pkg.sv
package chain_port_pkg;
  localparam int unsigned RES_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } port_state_e;
endpackage

// File: rtl/chain_port_rstsync.sv
module chain_port_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/chain_port_sync.sv
module chain_port_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], d_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= stg_d;
    end

    assign q_o[b] = stg_q[STAGES-1];
  end
endmodule

// File: rtl/chain_port_timer.sv
module chain_port_timer #(
  parameter int unsigned CONV_CYCLES = 40,
  localparam int unsigned CNT_W = (CONV_CYCLES < 2) ? 1 : $clog2(CONV_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (!run_i)              cnt_d = '0;
    else if (cnt_q == LAST)  cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/chain_port_shreg.sv
module chain_port_shreg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] sr_d;
  logic             sr_en;

  always_comb begin
    sr_en = load_i || shift_i;
    sr_d  = sr_q;
    if (load_i)       sr_d = par_i;
    else if (shift_i) sr_d = {sr_q[WIDTH-2:0], ser_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign q_o = sr_q;
endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port
  import chain_port_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 40,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o
);
  localparam int unsigned IDX_CNV = 0;
  localparam int unsigned IDX_SCK = 1;
  localparam int unsigned IDX_SDI = 2;
  localparam int unsigned N_IN    = 3;

  logic            rst_int_n;
  logic [N_IN-1:0] pins_raw;
  logic [N_IN-1:0] pins_s;
  logic [1:0]      edge_prev_q;
  logic [1:0]      edge_prev_d;
  logic            cnv_s, sck_s, sdi_s;
  logic            cnv_rise, cnv_fall, sck_fall;

  port_state_e     state_q, state_d;
  logic            conv_run, conv_done;
  logic            sr_load, sr_shift;
  logic [RES_W-1:0] sr_q;

  chain_port_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    pins_raw          = '0;
    pins_raw[IDX_CNV] = cnv_i;
    pins_raw[IDX_SCK] = sck_i;
    pins_raw[IDX_SDI] = sdi_i;
  end

  chain_port_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign cnv_s = pins_s[IDX_CNV];
  assign sck_s = pins_s[IDX_SCK];
  assign sdi_s = pins_s[IDX_SDI];

  always_comb begin
    edge_prev_d = {sck_s, cnv_s};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) edge_prev_q <= '0;
    else            edge_prev_q <= edge_prev_d;
  end

  assign cnv_rise = cnv_s && !edge_prev_q[0];
  assign cnv_fall = !cnv_s && edge_prev_q[0];
  assign sck_fall = !sck_s && edge_prev_q[1];

  chain_port_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (conv_run),
    .done_o (conv_done)
  );

  always_comb begin
    state_d  = state_q;
    conv_run = 1'b0;
    sr_load  = 1'b0;
    sr_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cnv_rise && !sck_s) state_d = ST_CONV;
      end
      ST_CONV: begin
        if (cnv_fall) begin
          state_d = ST_IDLE;
        end else begin
          conv_run = 1'b1;
          if (conv_done) begin
            sr_load = 1'b1;
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (cnv_fall) state_d = ST_IDLE;
        else          sr_shift = sck_fall;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  chain_port_shreg #(.WIDTH(RES_W)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (sr_load),
    .shift_i (sr_shift),
    .par_i   (result_i),
    .ser_i   (sdi_s),
    .q_o     (sr_q)
  );

  assign sdo_o = (state_q == ST_READ) ? sr_q[RES_W-1] : 1'b0;
endmodule

// File: rtl/chain_adc_port_chk.sv
module chain_adc_port_chk
  import chain_port_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnv_i,
  input logic             sdo_o,
  input port_state_e      state,
  input logic             sck_lvl,
  input logic             sck_fall,
  input logic             cnv_rise,
  input logic [RES_W-1:0] shreg
);
  localparam int unsigned CW = $clog2(CONV_CYCLES + 2);

  logic [2:0]    low_cnt;
  logic [CW-1:0] conv_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_cnt <= '0;
    else if (cnv_i)         low_cnt <= '0;
    else if (low_cnt != 3'd7) low_cnt <= low_cnt + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                conv_cnt <= '0;
    else if (state == ST_CONV) conv_cnt <= conv_cnt + 1'b1;
    else                       conv_cnt <= '0;
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt >= 3'd4) |-> !sdo_o); // R1

  AST_CONV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state == ST_CONV) && state == ST_READ) |-> (conv_cnt == CW'(CONV_CYCLES))); // R2

  AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && $past(state == ST_CONV)) |-> $stable(shreg)); // R3

  AST_NO_START_SCKHI: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cnv_rise && sck_lvl) |=> (state == ST_IDLE)); // R4

  AST_SDO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && $past(state == ST_READ) && !$past(sck_fall)) |-> $stable(sdo_o)); // R7
endmodule

bind chain_adc_port chain_adc_port_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnv_i    (cnv_i),
  .sdo_o    (sdo_o),
  .state    (state_q),
  .sck_lvl  (sck_s),
  .sck_fall (sck_fall),
  .cnv_rise (cnv_rise),
  .shreg    (sr_q)
);

// File: tb/sim_chain_adc_port.sv
`timescale 1ns/1ps
module sim_chain_adc_port;
  localparam int CONVC = 40;

  logic clk, rst_n;
  logic cnv_b, sck_b, sdi_b, sel_up;
  logic [15:0] res0, res_up;
  logic sdo0, sdo_up, sdi0;
  int   n_chk, n_fail;

  assign sdi0 = sel_up ? sdo_up : sdi_b;

  chain_adc_port #(.CONV_CYCLES(CONVC)) u0 (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv_b), .sck_i(sck_b), .sdi_i(sdi0),
    .result_i(res0), .sdo_o(sdo0)
  );

  chain_adc_port #(.CONV_CYCLES(CONVC)) u_up (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv_b), .sck_i(sck_b), .sdi_i(1'b0),
    .result_i(res_up), .sdo_o(sdo_up)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_stream(input logic [15:0] r, input logic [63:0] sp);
    logic [63:0] s;
    s = '0;
    for (int i = 0; i < 64; i++) s[i] = (i < 16) ? r[15-i] : sp[i-16];
    return s;
  endfunction

  task automatic start_conv(input logic [15:0] late_res, input bit swap);
    sck_b = 1'b0;
    cnv_b = 1'b1;
    tick(CONVC / 2);
    check(sdo0, 1'b0, "R2 low during conversion");
    if (swap) res0 = late_res;
    tick(CONVC / 2 + 8);
  endtask

  task automatic read_bits(input int n, input logic [63:0] exp, input logic [63:0] sp);
    logic b;
    for (int i = 0; i < n; i++) begin
      sdi_b = sp[i];
      b = sdo0;
      check(b, exp[i], (i < 16) ? "R5 result bit" : (sel_up ? "R10 chained bit" : "R6 passed bit"));
      sck_b = 1'b1;
      tick(4);
      check(sdo0, b, "R7 held over high phase");
      sck_b = 1'b0;
      tick(4);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] sp, ex;
    logic [15:0] r;
    int n;
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd7519));
    rst_n = 1'b0; cnv_b = 0; sck_b = 0; sdi_b = 0; sel_up = 0;
    res0 = 16'hA5C3; res_up = 16'h0000;
    tick(5);
    check(sdo0, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    tick(5);
    sdi_b = 1'b1;
    tick(6);
    check(sdo0, 1'b0, "R1 idle with data input high");
    sdi_b = 1'b0;

    // directed basic readback
    start_conv(16'h0, 0);
    sp = 64'h0000_0000_0000_00F1;
    read_bits(24, mk_stream(16'hA5C3, sp), sp);
    cnv_b = 0; tick(8);
    check(sdo0, 1'b0, "R8 idle after strobe fall");

    // random patterns, checked against the bench stream model
    for (int k = 0; k < 6; k++) begin
      r = 16'($urandom);
      res0 = r;
      sp = {$urandom, $urandom};
      n = 16 + int'($urandom % 9);
      start_conv(16'h0, 0);
      read_bits(n, mk_stream(r, sp), sp);
      cnv_b = 0; tick(8);
    end

    // R3: serial clock activity during conversion is ignored
    res0 = 16'h8001;
    cnv_b = 1'b1;
    tick(6);
    for (int j = 0; j < 3; j++) begin
      sck_b = 1; sdi_b = 1; tick(3);
      sck_b = 0; tick(3);
    end
    sdi_b = 0;
    tick(CONVC);
    sp = 64'h0;
    read_bits(16, mk_stream(16'h8001, sp), sp);
    cnv_b = 0; tick(8);

    // R4: start with serial clock high is ignored
    res0 = 16'hFFFF;
    sck_b = 1'b1; tick(4);
    cnv_b = 1'b1;
    tick(CONVC + 10);
    check(sdo0, 1'b0, "R4 no start with clock high");
    for (int j = 0; j < 4; j++) begin
      sck_b = 0; tick(4);
      check(sdo0, 1'b0, "R4 clock falls after refused start");
      sck_b = 1; tick(4);
    end
    sck_b = 0; cnv_b = 0; tick(8);

    // R9: result sampled at end of conversion
    res0 = 16'h1234;
    start_conv(16'hC0DE, 1);
    sp = 64'h0;
    read_bits(16, mk_stream(16'hC0DE, sp), sp);
    cnv_b = 0; tick(8);

    // R8: abort mid readback, then a fresh conversion
    res0 = 16'hFFFF;
    start_conv(16'h0, 0);
    read_bits(5, mk_stream(16'hFFFF, 64'h0), 64'h0);
    cnv_b = 0; tick(8);
    check(sdo0, 1'b0, "R8 output low after abort");
    sdi_b = 1; sck_b = 1; tick(4); sck_b = 0; tick(4);
    check(sdo0, 1'b0, "R1 idle ignores clock and data");
    sdi_b = 0;
    res0 = 16'h7F00;
    start_conv(16'h0, 0);
    read_bits(16, mk_stream(16'h7F00, 64'h0), 64'h0);
    cnv_b = 0; tick(8);

    // R10: two cascaded ports
    sel_up = 1'b1;
    res0 = 16'h3C5A; res_up = 16'hE817;
    start_conv(16'h0, 0);
    ex = mk_stream(16'h3C5A, {32'h0, 16'h0, 16'h0} | 64'(mk_stream(16'hE817, 64'h0)));
    read_bits(36, ex, 64'h0);
    cnv_b = 0; tick(8);
    check(sdo0, 1'b0, "R10 chain idle after strobe fall");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule